// File: doc/BRIEF.md
# Frame Fetch Sequencer

The block decides which memory words a raster display controller reads, and in what order. Software programs a palette base address and two frame buffers. Each frame buffer is a pair made of a base address and an inclusive ceiling address. On each frame-start pulse from the timing generator, the sequencer walks one region and issues burst read requests with a simple request/acknowledge handshake. Each burst carries a byte address and a length in 32-bit words. The last burst of a region is shortened, so no read goes past the ceiling.

A two-bit load mode selects the passes:
- palette followed by data;
- palette alone, after which fetching parks;
- data alone.

With dual buffering enabled, successive frames alternate between the two buffers. Completion and fault events are recorded in a sticky status register whose bits are cleared by writing ones. A single interrupt line merges the status groups that software has enabled. A FIFO underrun stops all new fetches. The sequencer then waits until software turns the raster off and on again.

Registers are written through a simple write port with a 3-bit word address. Address 7 is unused.

Top module: `fb_fetch_seq`

## Requirements
- R1: After reset, rd_req, status and irq are all 0.
- R2: Control bits [5:3] hold the burst code. Codes 0, 1, 2, 3 and 4 give maximum bursts of 1, 2, 4, 8 and 16 words. Codes 5 to 7 are treated as 1 word.
- R3: Address 3 holds the base and address 4 the inclusive ceiling of buffer 0. A data pass reads upward from the base, and each burst starts 4×length bytes after the previous one. The last burst is shortened so that its final byte is the ceiling.
- R4: Only one request is outstanding at a time. rd_req stays high with rd_addr and rd_len unchanged until rd_ack. A new burst is issued only when fifo_space is at least its length in words.
- R5: A buffer's base and ceiling are captured at frame start. A register write during a pass changes only the next pass.
- R6: Addresses 5 and 6 hold the base and ceiling of buffer 1. With control bit 6 set, frames alternate buffer 0, 1, 0, … starting from buffer 0 after enable. With bit 6 clear, only buffer 0 is read.
- R7: When the last burst of a data pass is acknowledged, status bit 8 is set for buffer 0 and status bit 9 is set for buffer 1.
- R8: Control bits [2:1] hold the load mode:
  - 0: the first frame start after enable runs a palette pass, and later frames run data passes.
  - 1: a palette pass runs, then no fetch happens until control bit 0 (enable) is cleared and set again.
  - 2: data passes only.
  The end of a palette pass sets status bit 6.
- R9: The palette pass starts at the palette base held at address 2. It covers 32 bytes (8 words) when control bit 7 is 0, and 512 bytes (128 words) when bit 7 is 1.
- R10: Status is at address 1, and its bits are sticky. Writing a 1 to a status bit clears that bit, and writing 0 leaves it unchanged.
- R11: irq is the OR of three terms: status bit 6 AND control bit 9; status bits 8 or 9 AND control bit 8; status bits 5 or 2 AND control bit 10.
- R12: An fifo_underrun pulse has effect only while the sequencer is enabled and armed or fetching. In that case it sets status bits 5 and 2 and blocks every new request until enable is cleared and set again. In any other state it changes nothing.
- R13: A frame-start pulse that arrives while a pass is in progress is ignored. It neither restarts the pass nor queues another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | AW | Register write data |
| frame_start | input | 1 | One-cycle frame-start pulse from the timing generator |
| fifo_space | input | SPACE_W | Free pixel FIFO space, in words |
| fifo_underrun | input | 1 | One-cycle FIFO underrun pulse |
| rd_req | output | 1 | Burst read request |
| rd_addr | output | AW | Byte address of the burst |
| rd_len | output | 5 | Burst length, in words |
| rd_ack | input | 1 | Burst request accepted |
| status | output | 10 | Sticky status bits |
| irq | output | 1 | Interrupt |

## Verification
The assertions assume three things about the inputs:
- rd_ack is raised only while a request is open.
- Every base address is word aligned, and every ceiling equals the base plus a whole number of words minus one.
- The burst code and the buffer registers are not rewritten in a way that breaks those alignments.

The bench keeps within these assumptions. All of its addresses are computed from word counts. It acknowledges only a visible request, after a rotating delay of zero to two cycles. It changes the burst code only while no pass is running.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

    localparam int LEN_W  = 5;
    localparam int STAT_W = 10;

    // status bit positions (software decodes these)
    localparam int SB_EOF1    = 9;
    localparam int SB_EOF0    = 8;
    localparam int SB_PALDONE = 6;
    localparam int SB_UNDERRUN = 5;
    localparam int SB_SYNCLOSS = 2;

    localparam logic [1:0] MODE_BOTH = 2'd0;
    localparam logic [1:0] MODE_PAL  = 2'd1;
    localparam logic [1:0] MODE_DATA = 2'd2;

    localparam logic [2:0] RA_CTRL    = 3'd0;
    localparam logic [2:0] RA_STAT    = 3'd1;
    localparam logic [2:0] RA_PALBASE = 3'd2;
    localparam logic [2:0] RA_BASE0   = 3'd3;
    localparam logic [2:0] RA_CEIL0   = 3'd4;
    localparam logic [2:0] RA_BASE1   = 3'd5;
    localparam logic [2:0] RA_CEIL1   = 3'd6;

    // control word: en is bit 0, uf_ie is bit 10
    typedef struct packed {
        logic       uf_ie;
        logic       pal_ie;
        logic       eof_ie;
        logic       pal_wide;
        logic       dual;
        logic [2:0] burst;
        logic [1:0] mode;
        logic       en;
    } ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_PAL,
        ST_DATA,
        ST_PARKED
    } fetch_state_e;

    function automatic logic [LEN_W-1:0] burst_words(input logic [2:0] code);
        logic [LEN_W-1:0] w;
        case (code)
            3'd0:    w = 5'd1;
            3'd1:    w = 5'd2;
            3'd2:    w = 5'd4;
            3'd3:    w = 5'd8;
            3'd4:    w = 5'd16;
            default: w = 5'd1;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/fbf_regs.sv
module fbf_regs
    import fbf_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_addr,
    input  logic [AW-1:0]     cfg_wdata,
    input  logic              set_pal_done,
    input  logic              set_eof0,
    input  logic              set_eof1,
    input  logic              set_underrun,
    output logic              en_o,
    output logic [1:0]        mode_o,
    output logic [2:0]        burst_o,
    output logic              dual_o,
    output logic              pal_wide_o,
    output logic [AW-1:0]     pal_base_o,
    output logic [AW-1:0]     base0_o,
    output logic [AW-1:0]     ceil0_o,
    output logic [AW-1:0]     base1_o,
    output logic [AW-1:0]     ceil1_o,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o
);

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [AW-1:0]     pal_base;
        logic [AW-1:0]     base0;
        logic [AW-1:0]     ceil0;
        logic [AW-1:0]     base1;
        logic [AW-1:0]     ceil1;
        logic [STAT_W-1:0] stat;
    } regs_s;

    regs_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cfg_wr) begin
            case (cfg_addr)
                RA_CTRL:    r_d.ctrl     = ctrl_t'(cfg_wdata[CTRL_W-1:0]);
                RA_STAT:    r_d.stat     = r_q.stat & ~cfg_wdata[STAT_W-1:0];
                RA_PALBASE: r_d.pal_base = cfg_wdata;
                RA_BASE0:   r_d.base0    = cfg_wdata;
                RA_CEIL0:   r_d.ceil0    = cfg_wdata;
                RA_BASE1:   r_d.base1    = cfg_wdata;
                RA_CEIL1:   r_d.ceil1    = cfg_wdata;
                default:    ;
            endcase
        end
        // new events win over a clearing write in the same cycle
        if (set_pal_done) r_d.stat[SB_PALDONE] = 1'b1;
        if (set_eof0)     r_d.stat[SB_EOF0]    = 1'b1;
        if (set_eof1)     r_d.stat[SB_EOF1]    = 1'b1;
        if (set_underrun) begin
            r_d.stat[SB_UNDERRUN] = 1'b1;
            r_d.stat[SB_SYNCLOSS] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign en_o       = r_q.ctrl.en;
    assign mode_o     = r_q.ctrl.mode;
    assign burst_o    = r_q.ctrl.burst;
    assign dual_o     = r_q.ctrl.dual;
    assign pal_wide_o = r_q.ctrl.pal_wide;
    assign pal_base_o = r_q.pal_base;
    assign base0_o    = r_q.base0;
    assign ceil0_o    = r_q.ceil0;
    assign base1_o    = r_q.base1;
    assign ceil1_o    = r_q.ceil1;
    assign status_o   = r_q.stat;

    assign irq_o = (r_q.stat[SB_PALDONE] & r_q.ctrl.pal_ie)
                 | ((r_q.stat[SB_EOF0] | r_q.stat[SB_EOF1]) & r_q.ctrl.eof_ie)
                 | ((r_q.stat[SB_UNDERRUN] | r_q.stat[SB_SYNCLOSS]) & r_q.ctrl.uf_ie);

    // R10
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && cfg_addr == RA_STAT) |=> ((status_o & $past(status_o)) == $past(status_o)));

    // R12
    fault_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[SB_UNDERRUN]) |-> status_o[SB_SYNCLOSS]);

endmodule

// File: rtl/fbf_fetch.sv
module fbf_fetch
    import fbf_pkg::*;
#(
    parameter int AW      = 32,
    parameter int SPACE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [1:0]       mode_i,
    input  logic [2:0]       burst_i,
    input  logic             dual_i,
    input  logic             pal_wide_i,
    input  logic [AW-1:0]    pal_base_i,
    input  logic [AW-1:0]    base0_i,
    input  logic [AW-1:0]    ceil0_i,
    input  logic [AW-1:0]    base1_i,
    input  logic [AW-1:0]    ceil1_i,
    input  logic             frame_start_i,
    input  logic [SPACE_W-1:0] fifo_space_i,
    input  logic             underrun_i,
    output logic             rd_req_o,
    output logic [AW-1:0]    rd_addr_o,
    output logic [LEN_W-1:0] rd_len_o,
    input  logic             rd_ack_i,
    output logic             set_pal_done_o,
    output logic             set_eof0_o,
    output logic             set_eof1_o,
    output logic             set_underrun_o
);

    localparam logic [AW-1:0] PAL_SMALL_SPAN = AW'(31);
    localparam logic [AW-1:0] PAL_WIDE_SPAN  = AW'(511);

    typedef struct packed {
        fetch_state_e     st;
        logic             buf_sel;
        logic             pal_owed;
        logic             stalled;
        logic             req;
        logic [LEN_W-1:0] len;
        logic [AW-1:0]    cur;
        logic [AW-1:0]    ceil;
    } fs_s;

    fs_s s_d, s_q;

    logic [AW-1:0]    rem_words;
    logic [LEN_W-1:0] max_len;
    logic [LEN_W-1:0] nxt_len;
    logic             last_burst;
    logic             space_ok;
    logic             fetching;
    logic             fault_now;

    always_comb begin
        rem_words  = ((s_q.ceil - s_q.cur) >> 2) + AW'(1);
        max_len    = burst_words(burst_i);
        nxt_len    = (rem_words < AW'(max_len)) ? rem_words[LEN_W-1:0] : max_len;
        last_burst = (AW'(s_q.len) == rem_words);
        space_ok   = 32'(fifo_space_i) >= 32'(nxt_len);
        fetching   = (s_q.st == ST_PAL) || (s_q.st == ST_DATA);
        fault_now  = underrun_i && en_i && !s_q.stalled &&
                     (fetching || s_q.st == ST_ARMED);
    end

    always_comb begin
        s_d            = s_q;
        set_pal_done_o = 1'b0;
        set_eof0_o     = 1'b0;
        set_eof1_o     = 1'b0;
        set_underrun_o = 1'b0;

        // leave idle when enabled and not halted by a fault
        if (s_q.st == ST_IDLE && en_i && !s_q.stalled) begin
            s_d.st       = ST_ARMED;
            s_d.buf_sel  = 1'b0;
            s_d.pal_owed = (mode_i != MODE_DATA);
        end

        // frame start opens a pass, ignored while one is running
        if (s_q.st == ST_ARMED && frame_start_i && en_i && !s_q.stalled) begin
            if (s_q.pal_owed) begin
                s_d.st   = ST_PAL;
                s_d.cur  = pal_base_i;
                s_d.ceil = pal_base_i + (pal_wide_i ? PAL_WIDE_SPAN : PAL_SMALL_SPAN);
            end else if (mode_i != MODE_PAL) begin
                s_d.st   = ST_DATA;
                s_d.cur  = s_q.buf_sel ? base1_i : base0_i;
                s_d.ceil = s_q.buf_sel ? ceil1_i : ceil0_i;
            end
        end

        // burst accepted
        if (s_q.req && rd_ack_i) begin
            s_d.req = 1'b0;
            s_d.cur = s_q.cur + (AW'(s_q.len) << 2);
            if (last_burst) begin
                if (s_q.st == ST_PAL) begin
                    set_pal_done_o = 1'b1;
                    s_d.pal_owed   = 1'b0;
                    s_d.st         = (mode_i == MODE_PAL) ? ST_PARKED : ST_ARMED;
                end else begin
                    set_eof0_o  = !s_q.buf_sel;
                    set_eof1_o  = s_q.buf_sel;
                    s_d.buf_sel = dual_i ? !s_q.buf_sel : 1'b0;
                    s_d.st      = ST_ARMED;
                end
            end
        end

        // next burst
        if (!s_q.req && fetching && en_i && !s_q.stalled && !fault_now && space_ok) begin
            s_d.req = 1'b1;
            s_d.len = nxt_len;
        end

        if (fault_now) begin
            set_underrun_o = 1'b1;
            s_d.stalled    = 1'b1;
        end

        // disable or fault: drop to idle once no request is open
        if (!en_i) s_d.stalled = 1'b0;
        if ((!en_i || s_d.stalled) && !s_d.req) s_d.st = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_req_o  = s_q.req;
    assign rd_addr_o = s_q.cur;
    assign rd_len_o  = s_q.len;

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o) && $stable(rd_len_o));

    // R4
    space_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req_o) |-> 32'($past(fifo_space_i)) >= 32'(rd_len_o));

    // R3
    ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (rd_addr_o + (AW'(rd_len_o) << 2) - AW'(1)) <= s_q.ceil);

    // R2
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (rd_len_o != '0) && (rd_len_o <= 5'd16));

    // R12
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.stalled |=> !$rose(rd_req_o));

    // R6
    single_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dual_i && $past(!dual_i) && s_q.st == ST_ARMED |-> !s_q.buf_sel);

endmodule

// File: rtl/fb_fetch_seq.sv
module fb_fetch_seq
    import fbf_pkg::*;
#(
    parameter int AW      = 32,
    parameter int SPACE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [2:0]         cfg_addr,
    input  logic [AW-1:0]      cfg_wdata,
    input  logic               frame_start,
    input  logic [SPACE_W-1:0] fifo_space,
    input  logic               fifo_underrun,
    output logic               rd_req,
    output logic [AW-1:0]      rd_addr,
    output logic [LEN_W-1:0]   rd_len,
    input  logic               rd_ack,
    output logic [STAT_W-1:0]  status,
    output logic               irq
);

    logic          en, dual, pal_wide;
    logic [1:0]    mode;
    logic [2:0]    burst;
    logic [AW-1:0] pal_base, base0, ceil0, base1, ceil1;
    logic          set_pal_done, set_eof0, set_eof1, set_underrun;

    fbf_regs #(.AW(AW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .set_pal_done (set_pal_done),
        .set_eof0     (set_eof0),
        .set_eof1     (set_eof1),
        .set_underrun (set_underrun),
        .en_o         (en),
        .mode_o       (mode),
        .burst_o      (burst),
        .dual_o       (dual),
        .pal_wide_o   (pal_wide),
        .pal_base_o   (pal_base),
        .base0_o      (base0),
        .ceil0_o      (ceil0),
        .base1_o      (base1),
        .ceil1_o      (ceil1),
        .status_o     (status),
        .irq_o        (irq)
    );

    fbf_fetch #(.AW(AW), .SPACE_W(SPACE_W)) u_fetch (
        .clk            (clk),
        .rst_n          (rst_n),
        .en_i           (en),
        .mode_i         (mode),
        .burst_i        (burst),
        .dual_i         (dual),
        .pal_wide_i     (pal_wide),
        .pal_base_i     (pal_base),
        .base0_i        (base0),
        .ceil0_i        (ceil0),
        .base1_i        (base1),
        .ceil1_i        (ceil1),
        .frame_start_i  (frame_start),
        .fifo_space_i   (fifo_space),
        .underrun_i     (fifo_underrun),
        .rd_req_o       (rd_req),
        .rd_addr_o      (rd_addr),
        .rd_len_o       (rd_len),
        .rd_ack_i       (rd_ack),
        .set_pal_done_o (set_pal_done),
        .set_eof0_o     (set_eof0),
        .set_eof1_o     (set_eof1),
        .set_underrun_o (set_underrun)
    );

endmodule

// File: tb/fb_fetch_seq_bench.sv
module fb_fetch_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        frame_start = 1'b0;
    logic [7:0]  fifo_space = 8'd255;
    logic        fifo_underrun = 1'b0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic [4:0]  rd_len;
    logic        rd_ack = 1'b0;
    logic [9:0]  status;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // expected pass, driven by the bench model
    logic [31:0] exp_addr = '0;
    logic [31:0] exp_ceil = '0;
    int exp_left = 0;
    int exp_bw = 1;
    int gap = 0;
    int nburst = 0;
    int n_exp = 0;

    always #10 clk = ~clk;

    fb_fetch_seq u_fb_fetch_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start), .fifo_space(fifo_space),
        .fifo_underrun(fifo_underrun), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_len(rd_len), .rd_ack(rd_ack), .status(status), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory side: acknowledges after a rotating 0..2 cycle delay and checks each burst
    always @(negedge clk) begin
        if (rd_ack) begin
            rd_ack = 1'b0;
        end else if (rd_req) begin
            if (gap != 0) begin
                gap = gap - 1;
            end else begin
                if (exp_left <= 0) begin
                    chk(1'b0, "R13 unexpected request", rd_addr, 32'h0);
                end else begin
                    n_exp = (exp_left < exp_bw) ? exp_left : exp_bw;
                    chk(rd_addr == exp_addr, "R3 burst address", rd_addr, exp_addr);
                    chk(32'(rd_len) == 32'(n_exp), "R2 burst length", 32'(rd_len), 32'(n_exp));
                    chk(rd_addr + 32'(rd_len) * 4 - 1 <= exp_ceil, "R3 ceiling",
                        rd_addr + 32'(rd_len) * 4 - 1, exp_ceil);
                    exp_addr = exp_addr + 32'(n_exp) * 4;
                    exp_left = exp_left - n_exp;
                end
                rd_ack = 1'b1;
                nburst++;
                gap = nburst % 3;
            end
        end
    end

    function automatic logic [31:0] ctrl_word(input bit en, input int mode, input int code,
                                              input bit dual, input bit wide, input bit eof_ie,
                                              input bit pal_ie, input bit uf_ie);
        return {21'd0, uf_ie, pal_ie, eof_ie, wide, dual, 3'(code), 2'(mode), en};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic expect_pass(input logic [31:0] base, input int words, input int bw);
        exp_addr = base;
        exp_left = words;
        exp_bw   = bw;
        exp_ceil = base + 32'(words) * 4 - 1;
    endtask

    task automatic pulse_fs();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic wait_pass();
        while (exp_left != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic set_buf0(input logic [31:0] base, input int words);
        wr(3'd3, base);
        wr(3'd4, base + 32'(words) * 4 - 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int sizes[5] = '{1, 2, 5, 16, 23};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(rd_req == 1'b0, "R1 rd_req", 32'(rd_req), 0);
        chk(status == 10'h0, "R1 status", 32'(status), 0);
        chk(irq == 1'b0, "R1 irq", 32'(irq), 0);

        // R2 R3 R7 R10: sweep burst codes and region sizes, buffer 0 only
        wr(3'd0, ctrl_word(1, 2, 0, 0, 0, 0, 0, 0));
        for (int c = 0; c < 5; c++) begin
            for (int s = 0; s < 5; s++) begin
                logic [31:0] b;
                b = 32'h1000 + 32'(c * 5 + s) * 32'h400;
                set_buf0(b, sizes[s]);
                wr(3'd0, ctrl_word(1, 2, c, 0, 0, 0, 0, 0));
                expect_pass(b, sizes[s], 1 << c);
                pulse_fs();
                wait_pass();
                chk(status == 10'h100, "R7 eof0 status", 32'(status), 32'h100);
                wr(3'd1, 32'h100);
                chk(status == 10'h0, "R10 clear by one", 32'(status), 0);
            end
        end

        // R2 illegal code gives single words
        set_buf0(32'h9000, 3);
        wr(3'd0, ctrl_word(1, 2, 6, 0, 0, 0, 0, 0));
        expect_pass(32'h9000, 3, 1);
        pulse_fs();
        wait_pass();
        wr(3'd1, 32'h3ff);

        // R5 R13: pair captured at frame start, extra frame start ignored
        wr(3'd0, ctrl_word(1, 2, 0, 0, 0, 0, 0, 0));
        set_buf0(32'h2000, 9);
        expect_pass(32'h2000, 9, 1);
        pulse_fs();
        set_buf0(32'h3000, 9);
        pulse_fs();
        wait_pass();
        repeat (10) @(negedge clk);
        chk(rd_req == 1'b0, "R13 no second pass", 32'(rd_req), 0);
        expect_pass(32'h3000, 9, 1);
        pulse_fs();
        wait_pass();
        chk(exp_addr == 32'h3024, "R5 new pair used", exp_addr, 32'h3024);
        wr(3'd1, 32'h3ff);

        // R4: no burst while fifo space is short
        wr(3'd0, ctrl_word(1, 2, 4, 0, 0, 0, 0, 0));
        set_buf0(32'h4000, 16);
        fifo_space = 8'd0;
        expect_pass(32'h4000, 16, 16);
        pulse_fs();
        repeat (10) @(negedge clk);
        chk(rd_req == 1'b0, "R4 space zero", 32'(rd_req), 0);
        fifo_space = 8'd15;
        repeat (10) @(negedge clk);
        chk(rd_req == 1'b0, "R4 space short", 32'(rd_req), 0);
        fifo_space = 8'd16;
        wait_pass();
        chk(exp_left == 0, "R4 burst after space", 32'(exp_left), 0);
        fifo_space = 8'd255;
        wr(3'd1, 32'h3ff);

        // R6 R7 R10: dual buffers alternate
        wr(3'd0, 32'h0);
        set_buf0(32'h5000, 6);
        wr(3'd5, 32'h6000);
        wr(3'd6, 32'h6000 + 10 * 4 - 1);
        wr(3'd0, ctrl_word(1, 2, 2, 1, 0, 0, 0, 0));
        for (int f = 0; f < 4; f++) begin
            if (f % 2 == 0) expect_pass(32'h5000, 6, 4);
            else            expect_pass(32'h6000, 10, 4);
            pulse_fs();
            wait_pass();
            if (f < 2) begin
                chk(status == ((f == 0) ? 10'h100 : 10'h300), "R6 R7 buffer status",
                    32'(status), (f == 0) ? 32'h100 : 32'h300);
            end else begin
                chk(status == ((f == 2) ? 10'h100 : 10'h200), "R6 R7 buffer status",
                    32'(status), (f == 2) ? 32'h100 : 32'h200);
                wr(3'd1, 32'h300);
            end
            if (f == 1) begin
                wr(3'd1, 32'h0);
                chk(status == 10'h300, "R10 zero write", 32'(status), 32'h300);
                wr(3'd1, 32'h100);
                chk(status == 10'h200, "R10 single clear", 32'(status), 32'h200);
                wr(3'd1, 32'h200);
            end
        end
        wr(3'd0, 32'h0);
        wr(3'd0, ctrl_word(1, 2, 2, 0, 0, 0, 0, 0));
        for (int f = 0; f < 2; f++) begin
            expect_pass(32'h5000, 6, 4);
            pulse_fs();
            wait_pass();
            chk(status == 10'h100, "R6 single buffer", 32'(status), 32'h100);
            wr(3'd1, 32'h300);
        end

        // R8 R9 R11: palette then data
        wr(3'd0, 32'h0);
        wr(3'd2, 32'h8000);
        wr(3'd0, ctrl_word(1, 0, 4, 0, 0, 0, 1, 0));
        expect_pass(32'h8000, 8, 16);
        pulse_fs();
        wait_pass();
        chk(status == 10'h040, "R8 palette done", 32'(status), 32'h40);
        chk(irq == 1'b1, "R11 palette irq", 32'(irq), 1);
        wr(3'd1, 32'h040);
        chk(irq == 1'b0, "R11 irq cleared", 32'(irq), 0);
        expect_pass(32'h5000, 6, 16);
        pulse_fs();
        wait_pass();
        chk(status == 10'h100, "R8 data after palette", 32'(status), 32'h100);
        chk(irq == 1'b0, "R11 eof masked", 32'(irq), 0);
        wr(3'd0, ctrl_word(1, 0, 4, 0, 0, 1, 1, 0));
        chk(irq == 1'b1, "R11 eof enabled", 32'(irq), 1);
        wr(3'd1, 32'h3ff);

        // R8 R9: palette only, wide palette, then parked
        wr(3'd0, 32'h0);
        wr(3'd0, ctrl_word(1, 1, 4, 0, 1, 0, 0, 0));
        expect_pass(32'h8000, 128, 16);
        pulse_fs();
        wait_pass();
        chk(status == 10'h040, "R9 wide palette done", 32'(status), 32'h40);
        wr(3'd1, 32'h040);
        pulse_fs();
        repeat (10) @(negedge clk);
        chk(rd_req == 1'b0, "R8 parked", 32'(rd_req), 0);
        chk(status == 10'h0, "R8 parked status", 32'(status), 0);
        wr(3'd0, 32'h0);
        wr(3'd0, ctrl_word(1, 2, 4, 0, 0, 0, 0, 0));
        expect_pass(32'h5000, 6, 16);
        pulse_fs();
        wait_pass();
        chk(status == 10'h100, "R8 data after re-enable", 32'(status), 32'h100);
        wr(3'd1, 32'h3ff);

        // R12 R11: underrun halts fetching
        wr(3'd0, ctrl_word(1, 2, 1, 0, 0, 0, 0, 1));
        @(negedge clk); fifo_underrun = 1'b1;
        @(negedge clk); fifo_underrun = 1'b0;
        @(negedge clk);
        chk(status == 10'h024, "R12 fault bits", 32'(status), 32'h24);
        chk(irq == 1'b1, "R11 fault irq", 32'(irq), 1);
        pulse_fs();
        repeat (10) @(negedge clk);
        chk(rd_req == 1'b0, "R12 halted", 32'(rd_req), 0);
        wr(3'd1, 32'h3ff);
        wr(3'd0, 32'h0);
        @(negedge clk); fifo_underrun = 1'b1;
        @(negedge clk); fifo_underrun = 1'b0;
        @(negedge clk);
        chk(status == 10'h0, "R12 ignored when off", 32'(status), 0);
        wr(3'd0, ctrl_word(1, 2, 1, 0, 0, 0, 0, 1));
        expect_pass(32'h5000, 6, 2);
        pulse_fs();
        wait_pass();
        chk(status == 10'h100, "R12 resume", 32'(status), 32'h100);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule